// File: doc/BRIEF.md
# Droop-Correcting FIR Filter for a CIC Decimator Output

This block is a fixed-coefficient FIR filter in transposed direct form. It is placed after a CIC decimator to flatten that decimator's passband droop. Each accepted input sample is a signed 32-bit word. The sample is multiplied at once by all 33 integer coefficients. The products are added into a chain of registers that moves one place toward the output on each accepted sample. The sum at the head of the chain is shifted right arithmetically by 15 bits and saturated back into the signed 32-bit range.

The integer coefficients add up to exactly 2^15, so a constant input leaves the filter unchanged once the chain has filled. The coefficients are compile-time constants and are checked at elaboration. A runtime select input lets the raw sample pass to the output instead of the filtered value. The filter chain keeps taking samples while bypass is selected, so switching bypass off again needs no refill time.

Top module: `cicc_fir`

## Requirements
- R1: With bypass low, every accepted sample n produces out_data = sat(floor((sum over k of c[k]*x[n-k]) / 2^15)). Here x is the stream of accepted samples, and samples from before the last reset count as zero.
- R2: There are 33 coefficients c[0..32], symmetric about c[16] = 49626. The coefficient at distance d = 1..16 from the centre is -12000, 5500, -3000, 1750, -1100, 700, -460, 300, -200, 130, -85, 55, -36, 22, -16, 11. The 33 values sum to exactly 32768.
- R3: After reset, one sample of value 32768 followed by zero samples gives out_data equal to c[0], c[1], ..., c[32], one value per accepted sample, in that order.
- R4: A run of accepted samples equal to 0x7FFFFFFF settles to out_data = 0x7FFFFFFF from the 33rd sample onward (unity DC gain).
- R5: The divide by 2^15 rounds toward minus infinity. Any result above 0x7FFFFFFF gives 0x7FFFFFFF, and any result below 0x80000000 gives 0x80000000.
- R6: out_valid is high in exactly the cycle after each cycle in which in_valid is high. When in_valid is low, out_data holds its value and the filter history does not advance.
- R7: When bypass_en is high with an accepted sample, out_data in the next cycle equals that raw sample. The sample still enters the filter history.
- R8: A synchronous, active-high rst clears the filter history, out_data (to 0) and out_valid (to 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the filter advances only when this is high |
| in_data | input | 32 | Signed input sample |
| bypass_en | input | 1 | High: pass the raw sample through; low: output the filtered value |
| out_valid | output | 1 | High one cycle after each accepted sample |
| out_data | output | 32 | Signed filtered or bypassed sample |

## Verification
The case hardest to reach from the ports is saturation. It needs a history in which each sample's sign matches the sign of its coefficient. The bench reaches it with a stream that alternates between full-scale positive and full-scale negative, which drives the sum to about three times full scale, past both limits. A second hard case is leaving bypass without losing history. The bench toggles bypass at random in the middle of a random stream and compares every filtered output with a convolution over all accepted samples, including those that went out unfiltered. Stalls on in_valid and a reset in the middle of a run are mixed in, so the bench also checks that the filter holds its history while stalled and that reset clears it.

// File: rtl/cicc_pkg.sv
package cicc_pkg;
   localparam int NTAPS  = 33;
   localparam int CENTER = (NTAPS - 1) / 2;
   localparam int DATA_W = 32;
   localparam int COEF_W = 18;
   localparam int FRAC   = 15;
   localparam int GUARD  = $clog2(NTAPS);
   localparam int ACC_W  = DATA_W + COEF_W + GUARD;

   // coefficient by distance from the centre tap; sign alternates, magnitude decays
   function automatic int coef_by_dist(input int d);
      case (d)
         0:  return 49626;
         1:  return -12000;
         2:  return 5500;
         3:  return -3000;
         4:  return 1750;
         5:  return -1100;
         6:  return 700;
         7:  return -460;
         8:  return 300;
         9:  return -200;
         10: return 130;
         11: return -85;
         12: return 55;
         13: return -36;
         14: return 22;
         15: return -16;
         16: return 11;
         default: return 0;
      endcase
   endfunction

   function automatic int tap_coef(input int k);
      int d;
      d = k - CENTER;
      if (d < 0) d = -d;
      return coef_by_dist(d);
   endfunction

   function automatic longint coef_sum();
      longint s;
      s = 0;
      for (int k = 0; k < NTAPS; k++) s += longint'(tap_coef(k));
      return s;
   endfunction

   function automatic longint coef_peak();
      longint m;
      m = 0;
      for (int k = 0; k < NTAPS; k++)
         if (longint'(tap_coef(k)) > m) m = longint'(tap_coef(k));
         else if (-longint'(tap_coef(k)) > m) m = -longint'(tap_coef(k));
      return m;
   endfunction
endpackage

// File: rtl/cicc_tap_chain.sv
// Transposed-form multiply/accumulate chain: every tap sees the same sample.
module cicc_tap_chain #(
   parameter int NTAPS = cicc_pkg::NTAPS,
   parameter int DW    = cicc_pkg::DATA_W,
   parameter int CW    = cicc_pkg::COEF_W,
   parameter int AW    = cicc_pkg::ACC_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [DW-1:0] x_i,
   output logic signed [AW-1:0] sum_o
);
   localparam int PW = DW + CW;

   logic signed [AW-1:0] prod [NTAPS];
   logic signed [AW-1:0] sr   [NTAPS-1];

   for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      localparam logic signed [CW-1:0] CK = CW'(cicc_pkg::tap_coef(k));
      logic signed [PW-1:0] mul;
      assign mul     = $signed({{CW{x_i[DW-1]}}, x_i}) * $signed({{DW{CK[CW-1]}}, CK});
      assign prod[k] = {{(AW-PW){mul[PW-1]}}, mul};
   end

   for (genvar k = 0; k < NTAPS - 1; k++) begin : g_stage
      if (k == NTAPS - 2) begin : g_tail
         always_ff @(posedge clk)
            if (rst)     sr[k] <= '0;
            else if (en) sr[k] <= prod[k+1];
      end else begin : g_body
         always_ff @(posedge clk)
            if (rst)     sr[k] <= '0;
            else if (en) sr[k] <= prod[k+1] + sr[k+1];
      end
   end

   assign sum_o = prod[0] + sr[0];
endmodule

// File: rtl/cicc_rescale.sv
// Arithmetic right shift by SHIFT and saturation to DW signed bits.
module cicc_rescale #(
   parameter int AW    = cicc_pkg::ACC_W,
   parameter int DW    = cicc_pkg::DATA_W,
   parameter int SHIFT = cicc_pkg::FRAC,
   parameter bit ROUND = 1'b0
) (
   input  logic signed [AW-1:0] acc_i,
   output logic signed [DW-1:0] y_o
);
   localparam logic signed [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

   logic signed [AW-1:0] biased;
   logic signed [AW-1:0] shifted;
   logic                 fits;

   if (ROUND) begin : g_round
      localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SHIFT - 1);
      assign biased = acc_i + HALF;
   end else begin : g_floor
      assign biased = acc_i;
   end

   assign shifted = biased >>> SHIFT;
   assign fits    = (&shifted[AW-1:DW-1]) | ~(|shifted[AW-1:DW-1]);

   always_comb begin
      if (fits)             y_o = shifted[DW-1:0];
      else if (shifted[AW-1]) y_o = NEG_MIN;
      else                  y_o = POS_MAX;
   end
endmodule

// File: rtl/cicc_fir.sv
module cicc_fir #(
   parameter int DATA_W = cicc_pkg::DATA_W,
   parameter int COEF_W = cicc_pkg::COEF_W,
   parameter int FRAC   = cicc_pkg::FRAC,
   parameter bit ROUND  = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     bypass_en,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int NTAPS = cicc_pkg::NTAPS;
   localparam int ACC_W = DATA_W + COEF_W + $clog2(NTAPS);

   if (NTAPS < 2) begin : g_bad_taps
      $error("cicc_fir: at least two taps required");
   end
   if (cicc_pkg::coef_sum() != (longint'(1) << FRAC)) begin : g_bad_gain
      $error("cicc_fir: coefficient sum must equal 2**FRAC");
   end
   if (cicc_pkg::coef_peak() >= (longint'(1) << (COEF_W - 1))) begin : g_bad_cw
      $error("cicc_fir: COEF_W too narrow for the coefficient set");
   end
   if (FRAC < 1 || FRAC >= ACC_W - DATA_W) begin : g_bad_frac
      $error("cicc_fir: FRAC out of range");
   end

   logic signed [ACC_W-1:0]  acc;
   logic signed [DATA_W-1:0] filt;

   cicc_tap_chain #(
      .NTAPS(NTAPS), .DW(DATA_W), .CW(COEF_W), .AW(ACC_W)
   ) u_chain (
      .clk(clk), .rst(rst), .en(in_valid), .x_i(in_data), .sum_o(acc)
   );

   cicc_rescale #(
      .AW(ACC_W), .DW(DATA_W), .SHIFT(FRAC), .ROUND(ROUND)
   ) u_scale (
      .acc_i(acc), .y_o(filt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= bypass_en ? in_data : filt;
      end
   end
endmodule

// File: rtl/cicc_fir_chk.sv
module cicc_fir_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [DW-1:0] in_data,
   input logic          bypass_en,
   input logic          out_valid,
   input logic [DW-1:0] out_data
);
   // R8
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

   // R6
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_data)));

   // R7
   bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && bypass_en) |=> out_data == $past(in_data));
endmodule

bind cicc_fir cicc_fir_chk #(.DW(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
   .bypass_en(bypass_en), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_cicc_fir.sv
module tb_cicc_fir;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        bypass_en = 1'b0;
   logic        out_valid;
   logic [31:0] out_data;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   cicc_fir dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .bypass_en(bypass_en), .out_valid(out_valid), .out_data(out_data)
   );

   // coefficients as listed in R2
   function automatic longint bc(input int k);
      int d;
      d = (k < 16) ? 16 - k : k - 16;
      case (d)
         0: return 49626;   1: return -12000; 2: return 5500;  3: return -3000;
         4: return 1750;    5: return -1100;  6: return 700;   7: return -460;
         8: return 300;     9: return -200;   10: return 130;  11: return -85;
         12: return 55;     13: return -36;   14: return 22;   15: return -16;
         default: return 11;
      endcase
   endfunction

   longint      hist [33];
   logic        ev;
   logic [31:0] ed;

   function automatic logic [31:0] model_out();
      longint acc;
      longint y;
      acc = 0;
      for (int k = 0; k < 33; k++) acc += bc(k) * hist[k];
      y = acc >>> 15;
      if (y > 64'sd2147483647) y = 64'sd2147483647;
      if (y < -64'sd2147483648) y = -64'sd2147483648;
      return y[31:0];
   endfunction

   task automatic check(input string tag, input logic ok,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive after a falling edge, predict, compare at the next falling edge
   task automatic cyc(input logic v, input logic [31:0] x, input logic b,
                      input logic r, input string tag);
      rst = r; in_valid = v; in_data = x; bypass_en = b;
      if (r) begin
         for (int k = 0; k < 33; k++) hist[k] = 0;
         ev = 1'b0; ed = '0;
      end else begin
         ev = v;
         if (v) begin
            for (int k = 32; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(x));
            ed = b ? x : model_out();
         end
      end
      @(negedge clk);
      check({tag, " valid"}, out_valid === ev, {31'd0, out_valid}, {31'd0, ev});
      check({tag, " data"}, out_data === ed, out_data, ed);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 33; k++) hist[k] = 0;
      ev = 1'b0; ed = '0;
      @(negedge clk);
      // R8 reset state
      cyc(0, 32'h0, 0, 1, "R8 reset");
      cyc(0, 32'h0, 0, 1, "R8 reset");

      // R3 / R2 impulse reproduces coefficients in order
      cyc(1, 32'd32768, 0, 0, "R3 impulse");
      check("R2/R3 c0", out_data === 32'(bc(0)), out_data, 32'(bc(0)));
      for (int i = 1; i < 33; i++) begin
         cyc(1, 32'h0, 0, 0, "R3 impulse");
         check("R2/R3 tap", out_data === 32'(bc(i)), out_data, 32'(bc(i)));
      end
      cyc(1, 32'h0, 0, 0, "R3 tail");

      // R4 step to full scale
      cyc(0, 32'h0, 0, 1, "R8 reset");
      for (int i = 0; i < 40; i++) cyc(1, 32'h7FFFFFFF, 0, 0, "R4 step");
      check("R4 settled", out_data === 32'h7FFFFFFF, out_data, 32'h7FFFFFFF);

      // R1 / R6 random stream with stalls
      for (int i = 0; i < 1500; i++)
         cyc(($urandom % 4) != 0, $urandom, 0, 0, "R1/R6 random");

      // R7 random bypass toggling; history keeps advancing
      for (int i = 0; i < 600; i++)
         cyc(($urandom % 3) != 0, $urandom, ($urandom % 4) == 0, 0, "R7 bypass");
      for (int i = 0; i < 40; i++)
         cyc(1, $urandom, 0, 0, "R7 after bypass");

      // R5 saturation: alternating full scale in phase with coefficient signs
      cyc(0, 32'h0, 0, 1, "R8 reset");
      for (int i = 0; i < 50; i++)
         cyc(1, (i % 2) ? 32'h80000000 : 32'h7FFFFFFF, 0, 0, "R5 saturate");
      check("R5 high/low clamp", out_data === 32'h7FFFFFFF || out_data === 32'h80000000,
            out_data, 32'h7FFFFFFF);
      // R5 floor: small negative values
      for (int i = 0; i < 40; i++) cyc(1, 32'hFFFFFFFF - (i % 3), 0, 0, "R5 floor");

      // R8 reset in mid-run clears history
      for (int i = 0; i < 10; i++) cyc(1, $urandom, 0, 0, "R1 prefill");
      cyc(1, $urandom, 0, 1, "R8 midrun reset");
      for (int i = 0; i < 35; i++) cyc(1, (i == 0) ? 32'd32768 : 32'h0, 0, 0, "R8 clean impulse");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule